// File: doc/BRIEF.md
# Serial Frame Receiver with Readback

This block is the front end of a three-wire serial slave. While the active-low chip select is held low, each rising edge of the serial clock shifts one bit from the data input into a 16-bit shift register, most significant bit first. A word is made of a 3-bit control field, then a 10-bit data field, then a 3-bit sub field. The host may send the word as one 16-bit burst or as two 8-bit bursts. Chip select has to stay low between the two bursts.

The captured word is only acted on when chip select rises. If exactly sixteen bits were shifted since chip select fell, the word is handed to a command decoder in the system clock domain. The handover is a one-cycle strobe, and the word and its split fields stay stable until the next accepted frame. Any other bit count discards the frame.

The serial output presents the most significant bit of the shift register. This allows readback of the previous word and daisy-chaining into the next device. A mode input, driven by the decoder, selects whether the output changes on the falling or the rising serial clock edge. All three serial pins are oversampled by the system clock through two-flop synchronizers.

Top module: `sfr_frame_rx`

## Requirements
- R1: After reset the serial output is 0, the strobe is low, the held word is 0x0000 and the shift register holds 0.
- R2: With chip select low, bits are sampled on rising serial clock edges, MSB first. When chip select rises after exactly 16 bits, a strobe appears and the held word equals the 16 bits in the order sent.
- R3: The control output is word bits [15:13], the data output is bits [12:3] and the sub output is bits [2:0].
- R4: A frame sent as two 8-bit bursts, with a pause and chip select held low between them, is accepted like a single 16-bit burst.
- R5: When chip select rises after a bit count other than 16 (for example 15 or 17), no strobe appears and the held word keeps its previous value.
- R6: While chip select is high, serial clock and data activity neither shifts the register nor produces a strobe.
- R7: When chip select falls, the serial output shows the MSB of the shift register. During a frame, the output carries the earlier register contents MSB first, followed by the new bits, each delayed by 16 clock edges.
- R8: With the mode input at 0, the serial output changes only after falling serial clock edges. It shows the MSB that results from the preceding rising edge.
- R9: With the mode input at 1, the serial output changes after each rising serial clock edge, to the MSB that results from that shift.
- R10: While chip select is high, the serial output is driven low.
- R11: The strobe lasts exactly one system clock cycle per accepted frame, and the held word changes only together with a strobe.
- R12: The bit counter clears on every chip select falling edge. A discarded short frame does not add to the count of the frame that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data input |
| dout_mode_i | input | 1 | Output launch edge: 0 falling, 1 rising |
| dout_o | output | 1 | Serial data output for readback and daisy-chaining |
| frame_valid_o | output | 1 | One-cycle strobe for an accepted frame |
| frame_word_o | output | 16 | Accepted 16-bit word |
| frame_ctrl_o | output | 3 | Control field of the accepted word |
| frame_data_o | output | 10 | Data field of the accepted word |
| frame_sub_o | output | 3 | Sub field of the accepted word |

## Verification
Words with asymmetric bit patterns are sent back to back, so the serial output during each frame must replay the previous word bit for bit; a reversed bit order or an off-by-one shift shows up at once. The output is sampled both at the end of the high phase and at the end of the low phase of the serial clock in each mode, which separates a falling-edge launch from a rising-edge launch. Frames of 15, 17, 8 and 8+8 bits, plus clock activity with chip select high, separate correct framing from counting that is off by one, never cleared, or not gated by chip select.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int CTRL_W  = 3;
  localparam int DATA_W  = 10;
  localparam int SUB_W   = 3;
  localparam int FRAME_W = CTRL_W + DATA_W + SUB_W;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0] data;
    logic [SUB_W-1:0]  sub;
  } frame_t;

  typedef enum logic {
    LAUNCH_FALL = 1'b0,
    LAUNCH_RISE = 1'b1
  } launch_e;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb stg_d = {stg_q[STAGES-2:0], async_i[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL[i]}};
      else        stg_q <= stg_d;
    end

    assign sync_o[i] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_sync_i,
  input  logic sclk_sync_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);
  logic cs_prev_q, sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_sync_i;
      sclk_prev_q <= sclk_sync_i;
    end
  end

  assign sclk_rise_o = sclk_sync_i & ~sclk_prev_q;
  assign sclk_fall_o = ~sclk_sync_i & sclk_prev_q;
  assign cs_fall_o   = ~cs_sync_i & cs_prev_q;
  assign cs_rise_o   = cs_sync_i & ~cs_prev_q;
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter
  import sfr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en_i,
  input  logic               din_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  output logic [FRAME_W-1:0] shreg_o,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_word_o
);
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               valid_q, valid_d;
  logic [FRAME_W-1:0] word_q, word_d;
  logic               word_en;

  always_comb begin
    shreg_d = shreg_q;
    if (shift_en_i) shreg_d = {shreg_q[FRAME_W-2:0], din_i};
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cs_fall_i)                        cnt_d = shift_en_i ? CNT_W'(1) : '0;
    else if (shift_en_i && (cnt_q != '1)) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    word_en = cs_rise_i && (cnt_q == CNT_W'(FRAME_W));
    valid_d = word_en;
    word_d  = word_en ? shreg_q : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign shreg_o       = shreg_q;
  assign frame_valid_o = valid_q;
  assign frame_word_o  = word_q;
endmodule

// File: rtl/sfr_dout.sv
module sfr_dout
  import sfr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_active_i,
  input  logic    cs_fall_i,
  input  logic    sclk_rise_i,
  input  logic    sclk_fall_i,
  input  launch_e mode_i,
  input  logic    msb_i,
  input  logic    next_msb_i,
  output logic    dout_o
);
  logic dout_q, dout_d;

  always_comb begin
    dout_d = dout_q;
    if (!cs_active_i)                              dout_d = 1'b0;
    else if (cs_fall_i)                            dout_d = msb_i;
    else if ((mode_i == LAUNCH_RISE) && sclk_rise_i) dout_d = next_msb_i;
    else if ((mode_i == LAUNCH_FALL) && sclk_fall_i) dout_d = msb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 1'b0;
    else        dout_q <= dout_d;
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/sfr_frame_rx.sv
module sfr_frame_rx
  import sfr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               din_i,
  input  logic               dout_mode_i,
  output logic               dout_o,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_word_o,
  output logic [CTRL_W-1:0]  frame_ctrl_o,
  output logic [DATA_W-1:0]  frame_data_o,
  output logic [SUB_W-1:0]   frame_sub_o
);
  logic [2:0]         sync_bus;
  logic               cs_sync, sclk_sync, din_sync;
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [FRAME_W-1:0] shreg;
  frame_t             fr;

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cs_n_i, sclk_i, din_i}),
    .sync_o  (sync_bus)
  );

  assign {cs_sync, sclk_sync, din_sync} = sync_bus;

  sfr_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_sync_i   (cs_sync),
    .sclk_sync_i (sclk_sync),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_fall_o   (cs_fall),
    .cs_rise_o   (cs_rise)
  );

  sfr_shifter u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_en_i    (sclk_rise & ~cs_sync),
    .din_i         (din_sync),
    .cs_fall_i     (cs_fall),
    .cs_rise_i     (cs_rise),
    .shreg_o       (shreg),
    .frame_valid_o (frame_valid_o),
    .frame_word_o  (frame_word_o)
  );

  sfr_dout u_dout (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_active_i (~cs_sync),
    .cs_fall_i   (cs_fall),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .mode_i      (launch_e'(dout_mode_i)),
    .msb_i       (shreg[FRAME_W-1]),
    .next_msb_i  (shreg[FRAME_W-2]),
    .dout_o      (dout_o)
  );

  assign fr           = frame_t'(frame_word_o);
  assign frame_ctrl_o = fr.ctrl;
  assign frame_data_o = fr.data;
  assign frame_sub_o  = fr.sub;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
  import sfr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cs_sync,
  input logic               cs_fall,
  input logic               sclk_rise,
  input logic               sclk_fall,
  input logic               dout_mode,
  input logic               dout,
  input logic               frame_valid,
  input logic [FRAME_W-1:0] frame_word
);
  logic [CNT_W-1:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rises_q <= '0;
    else if (cs_fall)                         rises_q <= sclk_rise ? CNT_W'(1) : '0;
    else if (sclk_rise && !cs_sync && rises_q != '1) rises_q <= rises_q + CNT_W'(1);
  end

  assert_full_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ($past(rises_q) == CNT_W'(FRAME_W)));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_word_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_word));

  assert_dout_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> !dout);

  assert_fall_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_sync && !cs_fall && !dout_mode && !sclk_fall) |=> $stable(dout));

  assert_rise_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_sync && !cs_fall && dout_mode && !sclk_rise) |=> $stable(dout));
endmodule

bind sfr_frame_rx sfr_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_sync     (cs_sync),
  .cs_fall     (cs_fall),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .dout_mode   (dout_mode_i),
  .dout        (dout_o),
  .frame_valid (frame_valid_o),
  .frame_word  (frame_word_o)
);

// File: tb/sfr_frame_rx_tb_top.sv
module sfr_frame_rx_tb_top;
  localparam int HP = 60;

  logic        clk, rst_n, sclk, cs_n, din, mode;
  logic        dout, fvalid;
  logic [15:0] fword;
  logic [2:0]  fctrl, fsub;
  logic [9:0]  fdata;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int doubles = 0;
  logic prev_valid = 1'b0;
  logic [15:0] mdl = 16'h0000;
  logic [15:0] held = 16'h0000;
  bit done = 0;

  sfr_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .dout_mode_i(mode), .dout_o(dout), .frame_valid_o(fvalid),
    .frame_word_o(fword), .frame_ctrl_o(fctrl), .frame_data_o(fdata),
    .frame_sub_o(fsub)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  always @(negedge clk) begin
    if (fvalid) pulses++;
    if (fvalid && prev_valid) doubles++;
    prev_valid = fvalid;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // shift n bits (MSB first) with chip select low; optional pause after gap bits
  task automatic xfer(logic [31:0] bits, int n, int gap, string tag);
    logic eb, ea;
    cs_n = 1'b0;
    #(HP);
    check({tag, " R7 msb at select"}, dout, mdl[15]);
    for (int k = 0; k < n; k++) begin
      din = bits[n-1-k];
      #(HP);
      eb  = mdl[15];
      mdl = {mdl[14:0], din};
      ea  = mdl[15];
      sclk = 1'b1;
      #(HP);
      if (mode) check({tag, " R9 after rise"}, dout, ea);
      else      check({tag, " R8 held over rise"}, dout, eb);
      sclk = 1'b0;
      #(HP);
      check({tag, " R7 after fall"}, dout, ea);
      if (gap > 0 && k == gap - 1) #(30 * 10);
    end
    #(HP);
    cs_n = 1'b1;
    #(100);
    check({tag, " R10 idle low"}, dout, 1'b0);
  endtask

  task automatic test_reset();
    check("R1 dout", dout, 1'b0);
    check("R1 valid", fvalid, 1'b0);
    check("R1 word", fword, 16'h0000);
  endtask

  task automatic test_frame(logic [15:0] w, bit m, int gap, string tag);
    int p0;
    mode = m;
    p0 = pulses;
    xfer({16'h0, w}, 16, gap, tag);
    check({tag, " one strobe"}, pulses - p0, 1);
    check({tag, " word"}, fword, w);
    check("R3 ctrl", fctrl, w[15:13]);
    check("R3 data", fdata, w[12:3]);
    check("R3 sub", fsub, w[2:0]);
    held = w;
  endtask

  task automatic test_bad_count(int n, string tag);
    int p0;
    p0 = pulses;
    xfer(32'h1ABCD_EF1 ^ 32'h5A5A_A5A5, n, 0, tag);
    check({tag, " no strobe"}, pulses - p0, 0);
    check({tag, " word kept"}, fword, held);
  endtask

  task automatic test_ignore();
    int p0;
    p0 = pulses;
    for (int k = 0; k < 6; k++) begin
      din = k[0];
      #(HP); sclk = 1'b1; #(HP); sclk = 1'b0;
    end
    #(HP);
    check("R6 no strobe", pulses - p0, 0);
    check("R6 dout low", dout, 1'b0);
    // readback during next frame must still show the unshifted model
    test_frame(16'h6D2B, 1'b0, 0, "R6 readback");
  endtask

  task automatic test_clear();
    int p0;
    p0 = pulses;
    xfer(32'h0000_00B7, 8, 0, "R12 short");
    check("R12 short no strobe", pulses - p0, 0);
    test_frame(16'h8E41, 1'b1, 0, "R12 next");
  endtask

  initial begin
    #(2_000_000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0; mode = 1'b0;
    #32 rst_n = 1'b1;
    #50;
    test_reset();
    test_frame(16'hA5C3, 1'b0, 0, "R2 mode0");
    test_frame(16'h3C5A, 1'b1, 0, "R2 mode1");
    test_frame(16'hF00D, 1'b0, 8, "R4 split");
    test_bad_count(15, "R5 fifteen");
    test_bad_count(17, "R5 seventeen");
    test_ignore();
    test_clear();
    test_frame(16'h0001, 1'b1, 8, "R4 split mode1");
    #(200);
    check("R11 single-cycle strobes", doubles, 0);
    finish_run();
  end
endmodule